// File: doc/BRIEF.md
# Channel/Gain Scan Sequencer Queue

This block holds the scan list for a multiplexed analog front end. Each list entry is one byte that pairs an input channel number with a gain code. A host loads the list through a simple write port. Writes land at consecutive addresses starting from zero, and the address of the latest write is kept as the restart point. While an acquisition runs, an address pointer selects the entry that drives the multiplexer and the gain stage. The pointer moves one step for each conversion-done strobe. After it uses the restart entry it returns to zero, so the list repeats for as long as the acquisition lasts.

Lists with more than one entry must keep their channels interleaved by parity and must have an even length. When a loaded list breaks either rule, a sticky violation flag is raised. A single-entry list is always accepted. A load-clear input prepares the block for a new list.

Top module: `cg_scan_queue`

## Requirements
- R1: After reset or a load-clear, host writes go to address 0, then 1, then 2, and so on, one address per accepted write.
- R2: The restart address always equals the address of the most recently accepted write. Reset sets it to 0.
- R3: `curEntry` is the byte stored at `curAddr`, shown in the same cycle. `curChan` is bits [3:0] of that byte and `curGain` is bits [7:4].
- R4: A conversion-done strobe while `acqRun` is high moves the pointer up by one. If the pointer is at the restart address, it goes to 0 instead.
- R5: An `acqStart` pulse sets the pointer to 0 on the next edge. This takes priority over a conversion strobe in the same cycle.
- R6: A queue with a single entry, including an unloaded queue after reset, stays at address 0 on every conversion.
- R7: A write while `acqRun` is high is ignored. It changes neither the memory, the write address nor the restart address.
- R8: In a list with more than one entry, an entry whose channel bit 0 differs from its address bit 0 sets `ruleViolation`. An offending entry at address 0 is flagged when address 1 is written.
- R9: If `acqStart` arrives while the restart address is even and nonzero (an odd list length greater than one), `ruleViolation` is set.
- R10: `ruleViolation` stays set until `loadClr`. `loadClr` clears the flag, resets the write address to 0, and cancels a write in the same cycle.
- R11: A conversion-done strobe while `acqRun` is low leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadClr | input | 1 | Starts a new list: write address to 0, flag cleared |
| wrEn | input | 1 | Host write strobe |
| wrData | input | 8 | Entry byte: gain [7:4], channel [3:0] |
| acqRun | input | 1 | High while an acquisition is running |
| acqStart | input | 1 | One-cycle pulse at the start of an acquisition |
| convDone | input | 1 | One-cycle pulse at the end of each conversion |
| curEntry | output | 8 | Entry at the current pointer |
| curChan | output | 4 | Channel field of the current entry |
| curGain | output | 4 | Gain field of the current entry |
| curAddr | output | 8 | Current pointer value |
| ruleViolation | output | 1 | Sticky flag for list rule violations |

## Verification
A wrong restart register first shows up as a missing or early return of `curAddr` to 0. That is seen on the conversion strobe that should reach the last entry, or the one just after it. A write address that has slipped puts entries at the wrong address, so `curEntry` shows the wrong byte on the first scan that reaches that address. It can also set `ruleViolation` on the very next write. A lost parity memory for entry 0 shows only on the write to address 1, where the flag stays low when it should rise. For these reasons the bench checks the pointer and the flag one cycle after every stimulus, and reads entries back by scanning the list.

// File: rtl/cgq_pkg.sv
package cgq_pkg;
  typedef struct packed {
    logic memWe;   // store wrData at the write address
    logic wrClr;   // new list: write address and flag to zero
    logic rdClr;   // force the pointer to zero
    logic rdStep;  // advance or wrap the pointer
  } cgqStrobe_t;
endpackage

// File: rtl/cgq_ctrl.sv
module cgq_ctrl
  import cgq_pkg::*;
(
  input  logic       loadClr,
  input  logic       wrEn,
  input  logic       acqRun,
  input  logic       acqStart,
  input  logic       convDone,
  output cgqStrobe_t strb
);
  always_comb begin
    strb.wrClr  = loadClr;
    strb.memWe  = wrEn && !acqRun && !loadClr;
    strb.rdClr  = acqStart;
    strb.rdStep = convDone && acqRun && !acqStart;
  end
endmodule

// File: rtl/cgq_dpath.sv
module cgq_dpath
  import cgq_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int ENTRY_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  cgqStrobe_t         strb,
  input  logic [ENTRY_W-1:0] wrData,
  output logic [ADDR_W-1:0]  wrAddr,
  output logic [ADDR_W-1:0]  restartAddr,
  output logic [ADDR_W-1:0]  rdAddr,
  output logic [ENTRY_W-1:0] rdEntry
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ENTRY_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (strb.memWe) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrAddr      <= '0;
      restartAddr <= '0;
    end else if (strb.wrClr) begin
      wrAddr <= '0;
    end else if (strb.memWe) begin
      restartAddr <= wrAddr;
      wrAddr      <= wrAddr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdAddr <= '0;
    end else if (strb.rdClr) begin
      rdAddr <= '0;
    end else if (strb.rdStep) begin
      rdAddr <= (rdAddr == restartAddr) ? '0 : rdAddr + 1'b1;
    end
  end

  assign rdEntry = mem[rdAddr];
endmodule

// File: rtl/cgq_rulecheck.sv
module cgq_rulecheck
  import cgq_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int ENTRY_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  cgqStrobe_t         strb,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [ENTRY_W-1:0] wrData,
  input  logic [ADDR_W-1:0]  restartAddr,
  output logic               violation
);
  logic head0Odd;     // entry at address 0 holds an odd channel
  logic parityBad;
  logic lengthBad;

  always_comb begin
    parityBad = 1'b0;
    if (wrAddr != '0) begin
      parityBad = (wrData[0] != wrAddr[0]) ||
                  ((wrAddr == ADDR_W'(1)) && head0Odd);
    end
    lengthBad = (restartAddr != '0) && !restartAddr[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      head0Odd  <= 1'b0;
      violation <= 1'b0;
    end else if (strb.wrClr) begin
      head0Odd  <= 1'b0;
      violation <= 1'b0;
    end else begin
      if (strb.memWe && (wrAddr == '0)) head0Odd <= wrData[0];
      if ((strb.memWe && parityBad) || (strb.rdClr && lengthBad))
        violation <= 1'b1;
    end
  end
endmodule

// File: rtl/cg_scan_queue.sv
module cg_scan_queue
  import cgq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CHAN_W = 4,
  parameter int GAIN_W = 4,
  localparam int ENTRY_W = CHAN_W + GAIN_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               loadClr,
  input  logic               wrEn,
  input  logic [ENTRY_W-1:0] wrData,
  input  logic               acqRun,
  input  logic               acqStart,
  input  logic               convDone,
  output logic [ENTRY_W-1:0] curEntry,
  output logic [CHAN_W-1:0]  curChan,
  output logic [GAIN_W-1:0]  curGain,
  output logic [ADDR_W-1:0]  curAddr,
  output logic               ruleViolation
);
  cgqStrobe_t        strb;
  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] restartAddr;

  cgq_ctrl u_ctrl (
    .loadClr (loadClr),
    .wrEn    (wrEn),
    .acqRun  (acqRun),
    .acqStart(acqStart),
    .convDone(convDone),
    .strb    (strb)
  );

  cgq_dpath #(.ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrData     (wrData),
    .wrAddr     (wrAddr),
    .restartAddr(restartAddr),
    .rdAddr     (curAddr),
    .rdEntry    (curEntry)
  );

  cgq_rulecheck #(.ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W)) u_rule (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .restartAddr(restartAddr),
    .violation  (ruleViolation)
  );

  assign curChan = curEntry[CHAN_W-1:0];
  assign curGain = curEntry[ENTRY_W-1:CHAN_W];
endmodule

// File: rtl/cgq_checker.sv
module cgq_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              loadClr,
  input logic              wrEn,
  input logic              acqRun,
  input logic              acqStart,
  input logic              convDone,
  input logic [ADDR_W-1:0] curAddr,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [ADDR_W-1:0] restartAddr,
  input logic              ruleViolation
);
  a_r1_write_advances: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !acqRun && !loadClr) |=> (wrAddr == ADDR_W'($past(wrAddr) + 1)));

  a_r2_restart_capture: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !acqRun && !loadClr) |=> (restartAddr == $past(wrAddr)));

  a_r4_step: assert property (@(posedge clk) disable iff (!rstN)
    (convDone && acqRun && !acqStart && (curAddr != restartAddr))
      |=> (curAddr == ADDR_W'($past(curAddr) + 1)));

  a_r4_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (convDone && acqRun && !acqStart && (curAddr == restartAddr)) |=> (curAddr == '0));

  a_r5_start_zero: assert property (@(posedge clk) disable iff (!rstN)
    acqStart |=> (curAddr == '0));

  a_r7_run_blocks_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && acqRun && !loadClr) |=> ($stable(wrAddr) && $stable(restartAddr)));

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (ruleViolation && !loadClr) |=> ruleViolation);

  a_r10_clear: assert property (@(posedge clk) disable iff (!rstN)
    loadClr |=> (!ruleViolation && (wrAddr == '0)));

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!acqStart && !(convDone && acqRun)) |=> $stable(curAddr));
endmodule

bind cg_scan_queue cgq_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .loadClr      (loadClr),
  .wrEn         (wrEn),
  .acqRun       (acqRun),
  .acqStart     (acqStart),
  .convDone     (convDone),
  .curAddr      (curAddr),
  .wrAddr       (wrAddr),
  .restartAddr  (restartAddr),
  .ruleViolation(ruleViolation)
);

// File: tb/sim_cg_scan_queue.sv
module sim_cg_scan_queue;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       loadClr = 1'b0, wrEn = 1'b0, acqRun = 1'b0;
  logic       acqStart = 1'b0, convDone = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] curEntry, curAddr;
  logic [3:0] curChan, curGain;
  logic       ruleViolation;

  int nRun = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  cg_scan_queue u0 (
    .clk(clk), .rstN(rstN), .loadClr(loadClr), .wrEn(wrEn), .wrData(wrData),
    .acqRun(acqRun), .acqStart(acqStart), .convDone(convDone),
    .curEntry(curEntry), .curChan(curChan), .curGain(curGain),
    .curAddr(curAddr), .ruleViolation(ruleViolation)
  );

  // kind: 0 write, 1 start, 2 convert, 3 load-clear | data | expected addr | expected flag
  localparam logic [18:0] VEC [0:28] = '{
    {2'd3, 8'h00, 8'd0, 1'b0},  // R10 clear
    {2'd0, 8'h30, 8'd0, 1'b0},  // R1 ch0 @0
    {2'd0, 8'h51, 8'd0, 1'b0},  // R8 ch1 @1 legal
    {2'd0, 8'h22, 8'd0, 1'b0},
    {2'd0, 8'h73, 8'd0, 1'b0},  // R2 restart 3
    {2'd1, 8'h00, 8'd0, 1'b0},  // R5
    {2'd2, 8'h00, 8'd1, 1'b0},  // R4
    {2'd2, 8'h00, 8'd2, 1'b0},
    {2'd2, 8'h00, 8'd3, 1'b0},
    {2'd2, 8'h00, 8'd0, 1'b0},  // R4 wrap
    {2'd2, 8'h00, 8'd1, 1'b0},
    {2'd3, 8'h00, 8'd1, 1'b0},  // R10 pointer untouched
    {2'd0, 8'h45, 8'd1, 1'b0},  // R6 single odd entry legal
    {2'd1, 8'h00, 8'd0, 1'b0},
    {2'd2, 8'h00, 8'd0, 1'b0},  // R6
    {2'd2, 8'h00, 8'd0, 1'b0},
    {2'd3, 8'h00, 8'd0, 1'b0},
    {2'd0, 8'h02, 8'd0, 1'b0},
    {2'd0, 8'h04, 8'd0, 1'b1},  // R8 even ch at odd addr
    {2'd1, 8'h00, 8'd0, 1'b1},  // R10 sticky
    {2'd3, 8'h00, 8'd0, 1'b0},
    {2'd0, 8'h01, 8'd0, 1'b0},
    {2'd0, 8'h03, 8'd0, 1'b1},  // R8 head entry flagged at addr 1
    {2'd3, 8'h00, 8'd0, 1'b0},
    {2'd0, 8'h00, 8'd0, 1'b0},
    {2'd0, 8'h11, 8'd0, 1'b0},
    {2'd0, 8'h22, 8'd0, 1'b0},
    {2'd1, 8'h00, 8'd0, 1'b1},  // R9 odd length
    {2'd3, 8'h00, 8'd0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one cycle of stimulus, return at the following falling edge
  task automatic drive(input logic wr, input logic [7:0] d, input logic st,
                       input logic cv, input logic clr, input logic run);
    @(negedge clk);
    wrEn = wr; wrData = d; acqStart = st; convDone = cv; loadClr = clr; acqRun = run;
    @(negedge clk);
    wrEn = 1'b0; acqStart = 1'b0; convDone = 1'b0; loadClr = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    drive(1'b1, d, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R2 reset addr", curAddr, 8'd0);
    check("R10 reset flag", ruleViolation, 1'b0);

    // R6: unloaded queue stays at 0
    drive(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1);
    drive(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1);
    check("R6 unloaded stays 0", curAddr, 8'd0);

    // vector table
    for (int i = 0; i < 29; i++) begin
      logic [1:0] k;
      k = VEC[i][18:17];
      drive(k == 2'd0, VEC[i][16:9], k == 2'd1, k == 2'd2, k == 2'd3,
            (k == 2'd1) || (k == 2'd2));
      check(k == 2'd0 ? "R8 vec flag" : k == 2'd1 ? "R9 vec flag" :
            k == 2'd2 ? "R4 vec flag" : "R10 vec flag", ruleViolation, VEC[i][0]);
      check(k == 2'd3 ? "R10 vec addr" : k == 2'd1 ? "R5 vec addr" : "R4 vec addr",
            curAddr, VEC[i][8:1]);
    end

    // R3 / R7: two-entry list, write during run ignored
    drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
    wr(8'h10);
    wr(8'h21);
    drive(1'b1, 8'h32, 1'b0, 1'b0, 1'b0, 1'b1);   // ignored
    drive(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R3 entry @0", curEntry, 8'h10);
    drive(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1);
    check("R3 entry @1", curEntry, 8'h21);
    check("R3 chan field", curChan, 4'h1);
    check("R3 gain field", curGain, 4'h2);
    drive(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1);
    check("R7 restart unchanged, wrap to 0", curAddr, 8'd0);
    check("R7 no flag from ignored write", ruleViolation, 1'b0);

    // R11: conversion while idle
    drive(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1);
    check("R4 step to 1", curAddr, 8'd1);
    drive(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R11 idle convert ignored", curAddr, 8'd1);

    // R5: start beats convert
    drive(1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1);
    check("R5 start priority", curAddr, 8'd0);

    // R10: clear cancels simultaneous write; next write lands at 0
    drive(1'b1, 8'h77, 1'b0, 1'b0, 1'b1, 1'b0);
    wr(8'h55);
    drive(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R10 write after clear at addr 0", curEntry, 8'h55);
    drive(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1);
    check("R1 single entry repeats", curAddr, 8'd0);
    check("R10 cancelled write left no flag", ruleViolation, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule